// File: doc/BRIEF.md
# Grouped Pin Toggle Interrupt Controller

This block watches a 24-bit bank of general-purpose pins and raises an interrupt flag when any selected pin changes level, in either direction. The pins are split into three groups of eight positions. Each group has its own 8-bit select register that picks which pins take part, a sticky flag, and an enable bit. Inside the middle group, position 15 is never wired, so that group has only seven usable pins.

Each pin passes through a capture stage and then a synchroniser stage. The block compares the two stages, masks the result per pin and registers the per-group result as a set pulse. The group flag picks up that pulse on the following clock edge. The block compares pin levels, not drive direction. Firmware that drives a pin as an output can therefore raise an interrupt on purpose by writing to that pin.

A flag stays set until software writes a one to its bit. The block has one combined request output, which is high while any flag has its enable bit set. Software reaches the registers through a simple single-cycle write port and a combinational read port.

Top module: `pin_toggle_irq`

## Requirements
- R1: While `rst_n` is low and after it rises, all select registers, flags and enable bits read back as zero, and `flag_o` and `irq_o` are low.
- R2: Group 0 covers pins 7..0, selected by the register at address 0. A level change on a selected pin sets `flag_o[0]`. Counting the rising clock edges after the pin change, the flag is still low after the second edge and high after the third.
- R3: Group 1 covers pins 14..8, selected by bits 6..0 of the register at address 1. Bit 7 of that register is not stored and reads as zero, and pin 15 never sets any flag.
- R4: Group 2 covers pins 23..16, selected by the register at address 2. A level change on a selected pin sets `flag_o[2]` only.
- R5: A level change on a pin whose select bit is zero sets no flag.
- R6: Flags are read at address 3, bits 2..0. Writing a one to a bit clears that flag. Writing a zero leaves the flag unchanged, and a flag never clears without such a write.
- R7: If a set pulse and a clearing write reach the same flag on the same clock edge, the flag ends up set.
- R8: Enable bits are at address 4, bits 2..0. `irq_o` is high exactly when some flag is set and its enable bit is set.
- R9: Pins that hold a non-zero pattern through reset raise no flag after reset is released.
- R10: Both a rising and a falling change on a selected pin set the group flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 24 | Watched pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0..4) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address (0..4) |
| rd_data | output | 8 | Read data, combinational |
| flag_o | output | 3 | Per-group sticky flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The main function is exercised with single-pin rising and falling changes on a selected pin in each group, which separates correct group routing from cross-group leakage. Changes on unselected pins and on the unwired position 15 show whether the per-pin masking is applied. A pin that toggles while a clearing write is in flight separates set priority from clear priority. A non-zero pin pattern held through reset separates a correctly seeded sampling pipeline from one that starts at zero.

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq #(
  parameter int NPINS = 24,
  parameter int NGRP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [NGRP-1:0]  flag_o,
  output logic             irq_o
);

  logic [NPINS-1:0] lat_q, syn_q;
  logic [7:0]       sel0_q, sel2_q;
  logic [6:0]       sel1_q;
  logic [NGRP-1:0]  en_q, set_q, flag_q, clr_v;
  logic [NPINS-1:0] eff_sel, tog;
  logic [NGRP-1:0]  set_d;

  assign eff_sel = {sel2_q, 1'b0, sel1_q, sel0_q};
  assign tog     = (lat_q ^ syn_q) & eff_sel;
  assign set_d   = {|tog[23:16], |tog[15:8], |tog[7:0]};
  assign clr_v   = (wr_en && wr_addr == 3'd3) ? wr_data[NGRP-1:0] : '0;

  always_ff @(posedge clk) begin
    lat_q <= pins_i;
    if (!rst_n) syn_q <= pins_i;
    else        syn_q <= lat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel0_q <= '0;
      sel1_q <= '0;
      sel2_q <= '0;
      en_q   <= '0;
      set_q  <= '0;
      flag_q <= '0;
    end else begin
      set_q  <= set_d;
      flag_q <= (flag_q & ~clr_v) | set_q;
      if (wr_en) begin
        case (wr_addr)
          3'd0: sel0_q <= wr_data;
          3'd1: sel1_q <= wr_data[6:0];
          3'd2: sel2_q <= wr_data;
          3'd4: en_q   <= wr_data[NGRP-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = sel0_q;
      3'd1:    rd_data = {1'b0, sel1_q};
      3'd2:    rd_data = sel2_q;
      3'd3:    rd_data = {5'b0, flag_q};
      3'd4:    rd_data = {5'b0, en_q};
      default: rd_data = 8'h00;
    endcase
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_q);

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q) & ~$past(clr_v)) == '0);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & $past(set_q)) == $past(set_q));

  assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0));

  assert_no_pin15_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_q[1] |-> $past((lat_q[14:8] ^ syn_q[14:8]) != 7'd0));

  assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_q[0] |-> $past(sel0_q != 8'd0));

endmodule

// File: tb/sim_pin_toggle_irq.sv
module sim_pin_toggle_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = 24'hA53C81;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [2:0]  flag_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pin_toggle_irq u0 (.clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_o(flag_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic flip(input int idx);
    @(negedge clk);
    pins[idx] = ~pins[idx];
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flag_o in reset", flag_o, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      chk("R1 register after reset", d, 0);
    end
    chk("R1 irq_o after reset", irq_o, 0);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    settle();
    chk("R9 no spurious flag with held pins", flag_o, 0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_group0();
    wr(3'd0, 8'h01);
    flip(0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 flag low after two edges", flag_o[0], 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 flag high after three edges", flag_o[0], 1);
    chk("R2 other groups untouched", flag_o[2:1], 0);
    wr(3'd3, 8'h07);
    chk("R6 flag cleared by write one", flag_o, 0);
    flip(0);
    settle();
    chk("R10 opposite direction change sets flag", flag_o[0], 1);
    wr(3'd3, 8'h07);
  endtask

  task automatic t_group1();
    logic [7:0] d;
    wr(3'd1, 8'hFF);
    rd(3'd1, d);
    chk("R3 bit 7 of group 1 select reads zero", d, 8'h7F);
    flip(15);
    settle();
    chk("R3 pin 15 raises no flag", flag_o, 0);
    flip(14);
    settle();
    chk("R3 pin 14 sets group 1 flag", flag_o, 3'b010);
    wr(3'd3, 8'h07);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_group2();
    wr(3'd2, 8'h80);
    flip(23);
    settle();
    chk("R4 pin 23 sets group 2 flag only", flag_o, 3'b100);
    wr(3'd3, 8'h07);
    flip(16);
    settle();
    chk("R5 unselected pin 16 raises no flag", flag_o, 0);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_mask();
    wr(3'd0, 8'h01);
    flip(3);
    settle();
    chk("R5 unselected pin 3 raises no flag", flag_o, 0);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    flip(0);
    settle();
    chk("R6 flag set before sticky test", flag_o[0], 1);
    wr(3'd3, 8'h00);
    chk("R6 writing zero keeps flag", flag_o[0], 1);
    wr(3'd3, 8'h06);
    chk("R6 clearing other bits keeps flag", flag_o[0], 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(3'd3, d);
    chk("R6 flag still set on readback", d, 8'h01);
  endtask

  task automatic t_set_wins();
    flip(0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 set wins over same-edge clear", flag_o[0], 1);
    wr(3'd3, 8'h01);
    chk("R7 later clear takes effect", flag_o[0], 0);
  endtask

  task automatic t_irq();
    flip(0);
    settle();
    chk("R8 no request with enables off", irq_o, 0);
    wr(3'd4, 8'h02);
    chk("R8 no request with other group enabled", irq_o, 0);
    wr(3'd4, 8'h01);
    chk("R8 request with matching enable", irq_o, 1);
    wr(3'd3, 8'h01);
    chk("R8 request drops after clear", irq_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_group0();
    t_group1();
    t_group2();
    t_mask();
    t_sticky();
    t_set_wins();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule